// File: doc/BRIEF.md
# Dual-Channel DMA Cycle Arbiter

This block decides who owns the shared bus for the next cycle slot. The slot can go to DMA channel 0, to DMA channel 1, or to the next processor instruction. A decision is taken only on the strobe that marks the end of a whole instruction cycle or a whole DMA transfer. Each channel supplies a request, a two-bit transfer mode and a completion flag. The processor side supplies the boundary strobe and flags that describe any DMA-register access made by the instruction now ending.

There are two mode families, and they behave differently. Block modes (burst and level demand) keep the bus for as long as the request stays high and the channel has not finished. Interleaved modes (alternate cycle and edge demand) always hand one instruction cycle back after each DMA cycle. When both channels run interleaved, they take turns between instructions. A channel 1 that joins a running interleaved channel 0 first waits one channel 0 turn.

The block also handles two bus handshakes:
- Requester handshake: when enabled, a request toward an external master is raised from the channel requests, and DMA slots are withheld until that master acknowledges.
- Foreign bus request: acknowledged only once no channel is busy or requesting, and it keeps the processor in instruction slots while it is held.

Top module: `dma_cycle_arbiter`

## Requirements
- R1: After reset the instruction grant is 1, both channel grants are 0, and bus_req_o and ext_bus_ack_o are 0.
- R2: Exactly one of grant_ch0_o, grant_ch1_o, grant_ins_o is high at all times. The grants change only on a clock edge where boundary_i is 1.
- R3: Mode codes are 0 = burst, 1 = alternate cycle, 2 = level demand, 3 = edge demand. Modes 1 and 3 are interleaved, and their DMA slot is always followed by an instruction slot. Modes 0 and 2 are block modes: the same channel keeps the grant while its request is high and done_i for it is low.
- R4: When both channels are idle and request together, channel 0 goes first. When both run interleaved, the slots repeat as channel 0, instruction, channel 1, instruction.
- R5: Suppose channel 0 is engaged in an interleaved mode when a channel 1 request (any mode) appears. Channel 1 is then first granted only after one further channel 0 slot and the instruction slot after it. A channel 1 block transfer, once started, runs to completion.
- R6: A channel 0 block transfer is never taken over by channel 1. A running channel 1 block transfer yields at the next boundary only to a channel 0 request in a demand mode (2 or 3). A channel 0 burst request waits until channel 1 completes.
- R7: If the instruction slot ending at a boundary made a DMA-register write, the next slot is an instruction. The same holds for a single-cycle DMA-register read (reg_rd_i with rd_two_cyc_i low). A read with rd_two_cyc_i high has no effect on the grant.
- R8: With requester_en_i high, bus_req_o is high one cycle after any channel request is seen, even while grants are held off. No DMA slot is granted while bus_ack_i is low. When the acknowledge arrives, channel 0 is served before channel 1.
- R9: ext_bus_ack_o rises one cycle after ext_bus_req_i once the instruction slot is granted and no channel is engaged or requesting. A transfer already queued is finished first. While the acknowledge is high, every boundary grants an instruction. It falls one cycle after ext_bus_req_i drops.
- R10: A boundary at which the granted channel has done_i set ends that transfer, and the next slot is an instruction unless a demand pre-emption applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | The current instruction cycle or DMA transfer ends this clock |
| reg_wr_i | input | 1 | The ending instruction wrote a DMA register |
| reg_rd_i | input | 1 | The ending instruction read a DMA register |
| rd_two_cyc_i | input | 1 | That read was a two-machine-cycle instruction |
| req_i | input | 2 | Channel requests, bit n for channel n |
| mode0_i | input | 2 | Channel 0 transfer mode |
| mode1_i | input | 2 | Channel 1 transfer mode |
| done_i | input | 2 | Channel n completes with its current slot |
| requester_en_i | input | 1 | Enable the outgoing bus request handshake |
| bus_ack_i | input | 1 | Acknowledge from the external bus master |
| ext_bus_req_i | input | 1 | Foreign master asks for the bus |
| bus_req_o | output | 1 | Outgoing bus request (requester handshake) |
| ext_bus_ack_o | output | 1 | Bus released to the foreign master |
| grant_ch0_o | output | 1 | Slot granted to channel 0 |
| grant_ch1_o | output | 1 | Slot granted to channel 1 |
| grant_ins_o | output | 1 | Slot granted to instruction execution |

## Verification
Any bad internal state shows up as a wrong grant at the first boundary that reads it:
- A wrong last-served bit or admission flag swaps the order of the interleaved rotation within two slots.
- A wrong engagement bit lets a waiting channel break into a block transfer.
- A broken hold-off shows as a DMA grant straight after a register-access boundary.
- A wrong acknowledge shows on ext_bus_ack_o one cycle after the foreign request or after the last channel request drops.

The vector sequence walks through each ordering rule boundary by boundary, so every state bit is exercised within a few slots of being set.

// File: rtl/dca_pkg.sv
package dca_pkg;
  localparam int MODE_W = 2;
  localparam int GR_W   = 2;

  localparam logic [GR_W-1:0] GR_INS = 2'd0;
  localparam logic [GR_W-1:0] GR_CH0 = 2'd1;
  localparam logic [GR_W-1:0] GR_CH1 = 2'd2;

  localparam logic [MODE_W-1:0] MD_BURST = 2'd0;
  localparam logic [MODE_W-1:0] MD_ALT   = 2'd1;
  localparam logic [MODE_W-1:0] MD_LEVEL = 2'd2;
  localparam logic [MODE_W-1:0] MD_EDGE  = 2'd3;

  // one DMA slot, then an instruction slot
  function automatic logic is_interleaved(input logic [MODE_W-1:0] m);
    return (m == MD_ALT) || (m == MD_EDGE);
  endfunction

  // keeps the bus while requesting
  function automatic logic is_block(input logic [MODE_W-1:0] m);
    return !is_interleaved(m);
  endfunction

  // demand modes may pre-empt a channel 1 block transfer
  function automatic logic is_demand(input logic [MODE_W-1:0] m);
    return (m == MD_LEVEL) || (m == MD_EDGE);
  endfunction
endpackage

// File: rtl/dca_access_gate.sv
module dca_access_gate (
  input  logic cur_ins,
  input  logic reg_wr,
  input  logic reg_rd,
  input  logic rd_two_cyc,
  input  logic requester_en,
  input  logic bus_ack,
  input  logic ext_ack,
  output logic reg_holdoff,
  output logic bus_wait,
  output logic gate_off
);
  always_comb begin
    reg_holdoff = cur_ins && (reg_wr || (reg_rd && !rd_two_cyc));
    bus_wait    = requester_en && !bus_ack;
    gate_off    = reg_holdoff || bus_wait || ext_ack;
  end
endmodule

// File: rtl/dca_pick.sv
module dca_pick
  import dca_pkg::*;
(
  input  logic [GR_W-1:0]   cur,
  input  logic [1:0]        req,
  input  logic [MODE_W-1:0] mode0,
  input  logic [MODE_W-1:0] mode1,
  input  logic [1:0]        done,
  input  logic [1:0]        eng,
  input  logic              adm1,
  input  logic              last1,
  input  logic              gate_off,
  output logic [GR_W-1:0]   nxt,
  output logic              preempt0
);
  logic cont0, cont1, el0, el1, pick1;

  always_comb begin
    preempt0 = (cur == GR_CH1) && is_block(mode1) && req[0] && is_demand(mode0);
    cont0 = (cur == GR_CH0) && is_block(mode0) && req[0] && !done[0];
    cont1 = (cur == GR_CH1) && is_block(mode1) && req[1] && !done[1] && !preempt0;
    el0   = req[0] && !(eng[1] && is_block(mode1) && !is_demand(mode0));
    el1   = req[1] && !(eng[0] && is_block(mode0))
                   && !(eng[0] && is_interleaved(mode0) && !adm1);
    pick1 = el1 && (!el0 || (adm1 && !last1 && is_interleaved(mode0)));

    nxt = GR_INS;
    if (gate_off)            nxt = GR_INS;
    else if (cur == GR_CH0)  nxt = cont0 ? GR_CH0 : GR_INS;
    else if (cur == GR_CH1)  nxt = cont1 ? GR_CH1 : (preempt0 ? GR_CH0 : GR_INS);
    else if (pick1)          nxt = GR_CH1;
    else if (el0)            nxt = GR_CH0;
  end
endmodule

// File: rtl/dca_bus_hold.sv
module dca_bus_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       requester_en,
  input  logic [1:0] req,
  input  logic [1:0] eng,
  input  logic       cur_ins,
  input  logic       ext_req,
  output logic       bus_req,
  output logic       ext_ack
);
  logic quiet;
  assign quiet = cur_ins && (eng == 2'b00) && (req == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req <= 1'b0;
      ext_ack <= 1'b0;
    end else begin
      bus_req <= requester_en && (req != 2'b00);
      ext_ack <= ext_req && (ext_ack || quiet);
    end
  end
endmodule

// File: rtl/dma_cycle_arbiter.sv
module dma_cycle_arbiter
  import dca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              rd_two_cyc_i,
  input  logic [1:0]        req_i,
  input  logic [MODE_W-1:0] mode0_i,
  input  logic [MODE_W-1:0] mode1_i,
  input  logic [1:0]        done_i,
  input  logic              requester_en_i,
  input  logic              bus_ack_i,
  input  logic              ext_bus_req_i,
  output logic              bus_req_o,
  output logic              ext_bus_ack_o,
  output logic              grant_ch0_o,
  output logic              grant_ch1_o,
  output logic              grant_ins_o
);
  logic [GR_W-1:0] cur_q, nxt_w;
  logic [1:0]      eng_q;
  logic            adm1_q, last1_q;
  logic            reg_holdoff_w, bus_wait_w, gate_off_w, preempt0_w;
  logic            cur_ins_w;

  assign cur_ins_w = (cur_q == GR_INS);

  dca_access_gate u_gate (
    .cur_ins(cur_ins_w), .reg_wr(reg_wr_i), .reg_rd(reg_rd_i),
    .rd_two_cyc(rd_two_cyc_i), .requester_en(requester_en_i),
    .bus_ack(bus_ack_i), .ext_ack(ext_bus_ack_o),
    .reg_holdoff(reg_holdoff_w), .bus_wait(bus_wait_w), .gate_off(gate_off_w)
  );

  dca_pick u_pick (
    .cur(cur_q), .req(req_i), .mode0(mode0_i), .mode1(mode1_i),
    .done(done_i), .eng(eng_q), .adm1(adm1_q), .last1(last1_q),
    .gate_off(gate_off_w), .nxt(nxt_w), .preempt0(preempt0_w)
  );

  dca_bus_hold u_hold (
    .clk(clk), .rst_n(rst_n), .requester_en(requester_en_i), .req(req_i),
    .eng(eng_q), .cur_ins(cur_ins_w), .ext_req(ext_bus_req_i),
    .bus_req(bus_req_o), .ext_ack(ext_bus_ack_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= GR_INS;
      last1_q <= 1'b0;
      adm1_q  <= 1'b0;
    end else begin
      if (boundary_i) begin
        cur_q <= nxt_w;
        if (nxt_w == GR_CH0) last1_q <= 1'b0;
        if (nxt_w == GR_CH1) last1_q <= 1'b1;
      end
      if (!req_i[1])                              adm1_q <= 1'b0;
      else if (boundary_i && nxt_w == GR_CH0)     adm1_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_eng
    localparam logic [GR_W-1:0] CODE = GR_W'(c + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        eng_q[c] <= 1'b0;
      else if (!req_i[c])                                eng_q[c] <= 1'b0;
      else if (boundary_i && cur_q == CODE && done_i[c]) eng_q[c] <= 1'b0;
      else if (boundary_i && nxt_w == CODE)              eng_q[c] <= 1'b1;
    end
  end

  assign grant_ch0_o = (cur_q == GR_CH0);
  assign grant_ch1_o = (cur_q == GR_CH1);
  assign grant_ins_o = (cur_q == GR_INS);
endmodule

// File: rtl/dca_arbiter_chk.sv
module dca_arbiter_chk
  import dca_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              reg_wr_i,
  input logic [1:0]        req_i,
  input logic [MODE_W-1:0] mode0_i,
  input logic [1:0]        done_i,
  input logic              requester_en_i,
  input logic              bus_ack_i,
  input logic              bus_req_o,
  input logic              ext_bus_ack_o,
  input logic              grant_ch0_o,
  input logic              grant_ch1_o,
  input logic              grant_ins_o
);
  logic [2:0] gv;
  assign gv = {grant_ins_o, grant_ch1_o, grant_ch0_o};

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(gv)); // R2
  AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !boundary_i |=> $stable(gv)); // R2
  AST_INTERLEAVE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && grant_ch0_o && is_interleaved(mode0_i) |=> grant_ins_o); // R3
  AST_CH0_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && grant_ch0_o && mode0_i == MD_BURST && req_i[0] && !done_i[0]
    && !(requester_en_i && !bus_ack_i) |=> grant_ch0_o); // R6
  AST_REG_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && grant_ins_o && reg_wr_i |=> grant_ins_o); // R7
  AST_BUS_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    requester_en_i && (req_i != 2'b00) |=> bus_req_o); // R8
  AST_NO_ACK_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && requester_en_i && !bus_ack_i |=> grant_ins_o); // R8
  AST_EXT_ACK_INS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bus_ack_o |-> grant_ins_o); // R9
endmodule

bind dma_cycle_arbiter dca_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .reg_wr_i(reg_wr_i),
  .req_i(req_i), .mode0_i(mode0_i), .done_i(done_i),
  .requester_en_i(requester_en_i), .bus_ack_i(bus_ack_i),
  .bus_req_o(bus_req_o), .ext_bus_ack_o(ext_bus_ack_o),
  .grant_ch0_o(grant_ch0_o), .grant_ch1_o(grant_ch1_o), .grant_ins_o(grant_ins_o)
);

// File: tb/dma_cycle_arbiter_tb.sv
module dma_cycle_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [1:0] I = 2'd0, C0 = 2'd1, C1 = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boundary_i = 0, reg_wr_i = 0, reg_rd_i = 0, rd_two_cyc_i = 0;
  logic [1:0] req_i = 0, mode0_i = 0, mode1_i = 0, done_i = 0;
  logic requester_en_i = 0, bus_ack_i = 0, ext_bus_req_i = 0;
  logic bus_req_o, ext_bus_ack_o, grant_ch0_o, grant_ch1_o, grant_ins_o;
  int n_chk = 0, n_fail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cycle_arbiter dut_i (.*);

  // row: tag[16:13] req[12:11] m0[10:9] m1[8:7] done[6:5] wr[4] rd[3] rd2[2] exp[1:0]
  function automatic logic [16:0] mk(input logic [3:0] t, input logic [1:0] r,
      input logic [1:0] a, input logic [1:0] b, input logic [1:0] d,
      input logic w, input logic rr, input logic r2, input logic [1:0] e);
    return {t, r, a, b, d, w, rr, r2, e};
  endfunction

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3: return "R3"; 4'd4: return "R4"; 4'd5: return "R5";
      4'd6: return "R6"; 4'd7: return "R7"; default: return "R10";
    endcase
  endfunction

  localparam int NV = 50;
  localparam logic [16:0] VEC [NV] = '{
    mk(4,3,1,1,0,0,0,0,C0), mk(3,3,1,1,0,0,0,0,I),  mk(4,3,1,1,0,0,0,0,C1), // R4 rotation
    mk(4,3,1,1,0,0,0,0,I),  mk(4,3,1,1,0,0,0,0,C0), mk(4,3,1,1,0,0,0,0,I),
    mk(7,3,1,1,0,1,0,0,I),  mk(4,3,1,1,0,0,0,0,C1), mk(4,3,1,1,0,0,0,0,I),  // R7 write
    mk(7,3,1,1,0,0,1,1,C0), mk(4,3,1,1,0,0,0,0,I),  mk(7,3,1,1,0,0,1,0,I),  // R7 reads
    mk(4,3,1,1,0,0,0,0,C1), mk(3,0,1,1,0,0,0,0,I),  mk(3,0,1,1,0,0,0,0,I),
    mk(6,2,0,0,0,0,0,0,C1), mk(3,2,0,0,0,0,0,0,C1), mk(6,3,0,0,0,0,0,0,C1), // R6 ch0 burst waits
    mk(10,3,0,0,2,0,0,0,I), mk(6,1,0,0,0,0,0,0,C0), mk(6,3,0,0,0,0,0,0,C0),
    mk(10,3,0,0,1,0,0,0,I), mk(6,2,0,0,0,0,0,0,C1), mk(6,3,2,0,0,0,0,0,C0), // R6 level pre-empt
    mk(6,3,2,0,0,0,0,0,C0), mk(6,2,2,0,0,0,0,0,I),  mk(6,2,2,0,0,0,0,0,C1),
    mk(6,3,3,0,0,0,0,0,C0), mk(3,3,3,0,0,0,0,0,I),  mk(6,2,3,0,0,0,0,0,C1), // R6 edge pre-empt
    mk(10,2,3,0,2,0,0,0,I), mk(3,0,0,0,0,0,0,0,I),
    mk(5,1,1,0,0,0,0,0,C0), mk(5,1,1,0,0,0,0,0,I),  mk(5,3,1,0,0,0,0,0,C0), // R5 burst join
    mk(5,3,1,0,0,0,0,0,I),  mk(5,3,1,0,0,0,0,0,C1), mk(5,3,1,0,0,0,0,0,C1),
    mk(10,3,1,0,2,0,0,0,I), mk(5,1,1,0,0,0,0,0,C0), mk(5,0,1,0,0,0,0,0,I),
    mk(5,1,1,1,0,0,0,0,C0), mk(5,3,1,1,0,0,0,0,I),  mk(5,3,1,1,0,0,0,0,C0), // R5 alt join
    mk(5,3,1,1,0,0,0,0,I),  mk(5,3,1,1,0,0,0,0,C1), mk(5,3,1,1,0,0,0,0,I),
    mk(5,3,1,1,0,0,0,0,C0), mk(5,0,1,1,0,0,0,0,I),  mk(5,0,1,1,0,0,0,0,I)
  };

  function automatic logic [1:0] gcode();
    if (grant_ch0_o && !grant_ch1_o && !grant_ins_o) return C0;
    if (grant_ch1_o && !grant_ch0_o && !grant_ins_o) return C1;
    if (grant_ins_o && !grant_ch0_o && !grant_ch1_o) return I;
    return 2'd3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    boundary_i = b;
    @(posedge clk);
    @(negedge clk);
    boundary_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; req_i = 0; mode0_i = 0; mode1_i = 0; done_i = 0;
    reg_wr_i = 0; reg_rd_i = 0; rd_two_cyc_i = 0;
    requester_en_i = 0; bus_ack_i = 0; ext_bus_req_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 grant", gcode(), I);
    check("R1 bus_req", bus_req_o, 0);
    check("R1 ext_ack", ext_bus_ack_o, 0);

    for (int k = 0; k < NV; k++) begin
      logic [16:0] v;
      v = VEC[k];
      req_i = v[12:11]; mode0_i = v[10:9]; mode1_i = v[8:7]; done_i = v[6:5];
      reg_wr_i = v[4]; reg_rd_i = v[3]; rd_two_cyc_i = v[2];
      tick(1);
      check(tag_name(v[16:13]), gcode(), v[1:0]);
    end

    // R2: no change between boundaries
    do_reset();
    req_i = 2'b01; mode0_i = 0;
    for (int k = 0; k < 3; k++) begin
      tick(0);
      check("R2 idle hold", gcode(), I);
    end
    tick(1);  check("R2 boundary", gcode(), C0);
    req_i = 0; tick(0);
    check("R2 mid transfer", gcode(), C0);
    tick(1);  check("R2 release", gcode(), I);

    // R8 requester handshake
    do_reset();
    requester_en_i = 1; req_i = 2'b01;
    tick(0);  check("R8 bus_req raise", bus_req_o, 1);
    reg_wr_i = 1; tick(1);
    check("R8 no ack grant", gcode(), I);
    check("R8 bus_req during holdoff", bus_req_o, 1);
    reg_wr_i = 0; req_i = 2'b11; bus_ack_i = 1;
    tick(1);  check("R8 ch0 first", gcode(), C0);
    req_i = 2'b10; done_i = 2'b01; tick(1);
    check("R10 done", gcode(), I);
    done_i = 0; tick(1);
    check("R8 ch1 second", gcode(), C1);
    req_i = 0; tick(0);
    check("R8 bus_req drop", bus_req_o, 0);

    // R9 foreign bus request
    do_reset();
    req_i = 2'b01; tick(1);
    check("R9 ch0 start", gcode(), C0);
    ext_bus_req_i = 1; tick(0); tick(0);
    check("R9 wait busy", ext_bus_ack_o, 0);
    req_i = 2'b11; done_i = 2'b01; tick(1);
    check("R9 ch0 end", gcode(), I);
    req_i = 2'b10; done_i = 0; tick(1);
    check("R9 second transfer", gcode(), C1);
    check("R9 still no ack", ext_bus_ack_o, 0);
    done_i = 2'b10; tick(1);
    check("R9 ch1 end", gcode(), I);
    req_i = 0; done_i = 0; tick(0);
    check("R9 ack", ext_bus_ack_o, 1);
    req_i = 2'b01; tick(1);
    check("R9 bus released", gcode(), I);
    ext_bus_req_i = 0; tick(0);
    check("R9 ack drop", ext_bus_ack_o, 0);
    tick(1);
    check("R9 resume", gcode(), C0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule